// File: doc/BRIEF.md
# Shared-Register Restoring Divider

This block divides one unsigned integer by another over several clock cycles and returns the quotient and the remainder. The caller presents a dividend and a divisor and raises `start` while `ready` is high. The block then runs one restoring trial per cycle. It raises `done` for a single cycle when both results are valid, and it keeps them on its outputs until the next operation is accepted.

All partial-remainder and quotient state lives in one shift register of 2N+1 bits. The partial remainder grows in the upper part and quotient bits enter at the least significant end as the register moves left. The trial subtractor sees only the upper part, which is one bit wider than the divisor. The register is pre-shifted at load time, which saves one iteration. This leaves the final remainder one position too far left, so it is read back shifted right by one. A zero divisor is not trapped: the block runs its normal sequence and flags the condition alongside `done`.

Top module: `shreg_divider`

## Requirements
- R1: After reset `ready` is 1, while `done` and `div_by_zero` are 0.
- R2: An operation is accepted only on a rising clock edge where `start` and `ready` are both 1. A `start` raised while the block is busy has no effect on the operation in progress or on its results.
- R3: `done` is 1 for exactly one cycle. It rises N+1 clock edges after the accepting edge, counting the accepting edge as the first.
- R4: When `done` is 1 and the divisor was non-zero, `quotient` equals floor(dividend / divisor) for the operands captured at acceptance.
- R5: When `done` is 1 and the divisor was non-zero, `remainder` equals dividend − quotient·divisor, and this value is strictly less than the divisor.
- R6: `div_by_zero` is 1 exactly in the `done` cycle of an operation whose captured divisor was zero, and 0 at every other time. Quotient and remainder are unspecified in that case.
- R7: `quotient` and `remainder` stay unchanged from the `done` cycle until the next accepted `start`, whatever the operand inputs do.
- R8: `ready` is 0 from the cycle after acceptance through the `done` cycle, and 1 again in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a division; taken when `ready` is 1 |
| dividend | input | N | Unsigned dividend, captured at acceptance |
| divisor | input | N | Unsigned divisor, captured at acceptance |
| ready | output | 1 | Block is idle and will accept `start` |
| done | output | 1 | One-cycle pulse: results are valid |
| quotient | output | N | Unsigned quotient |
| remainder | output | N | Unsigned remainder |
| div_by_zero | output | 1 | Captured divisor was zero; valid with `done` |

## Verification
The bench builds the block with N = 8. With that width, operands at both ends of the range can be reached cheaply: all-ones values, divisors with the top bit set, and a divisor larger than the dividend. Divisors with the top bit set make the partial remainder use the extra bit above the divisor width in the trial step. At this width a few hundred random operand pairs also cover a large share of the divisor range. The same width keeps each latency count, N+1 edges, short enough to check edge by edge.

// File: rtl/shreg_div_pkg.sv
package shreg_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } div_state_e;
endpackage

// File: rtl/shreg_div_ctrl.sv
module shreg_div_ctrl
  import shreg_div_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic ready,
  output logic fin
);
  localparam int unsigned CW = $clog2(N + 1);

  div_state_e     state_q;
  logic [CW-1:0]  iter_q;
  logic           last_iter;

  assign ready     = (state_q == ST_IDLE);
  assign load      = ready && start;
  assign step      = (state_q == ST_RUN);
  assign fin       = (state_q == ST_DONE);
  assign last_iter = (iter_q == CW'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_RUN;
          iter_q  <= '0;
        end
        ST_RUN: begin
          iter_q <= iter_q + 1'b1;
          if (last_iter) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: the iteration counter never passes the last trial
  a_r3_iter_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (iter_q < CW'(N)));
  // R8: the block is never idle in the cycle after a load
  a_r8_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> step);
endmodule

// File: rtl/shreg_div_datapath.sv
module shreg_div_datapath #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         fin,
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder,
  output logic         zero_div
);
  localparam int unsigned RW = 2 * N + 1;
  localparam int unsigned HW = N + 1;

  typedef struct packed {
    logic          fits;
    logic [HW-1:0] kept;
  } trial_t;

  // one restoring trial on the upper part of the shared register
  function automatic trial_t restoring_trial(input logic [HW-1:0] hi,
                                             input logic [N-1:0]  dv);
    logic [HW:0] diff;
    trial_t      t;
    diff   = {1'b0, hi} - {2'b00, dv};
    t.fits = ~diff[HW];
    t.kept = t.fits ? diff[HW-1:0] : hi;
    return t;
  endfunction

  logic [RW-1:0] acc_q;
  logic [N-1:0]  dv_q;
  logic          zero_q;
  logic [HW-1:0] acc_hi;
  logic [N-1:0]  acc_lo;
  trial_t        trial;
  logic          trial_fits;

  assign acc_hi     = acc_q[RW-1:N];
  assign acc_lo     = acc_q[N-1:0];
  assign trial      = restoring_trial(acc_hi, dv_q);
  assign trial_fits = trial.fits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      dv_q   <= '0;
      zero_q <= 1'b0;
    end else if (load) begin
      acc_q  <= {{N{1'b0}}, dividend, 1'b0};
      dv_q   <= divisor;
      zero_q <= (divisor == '0);
    end else if (step) begin
      acc_q  <= {trial.kept[N-1:0], acc_lo, trial_fits};
    end
  end

  assign quotient  = acc_lo;
  assign remainder = acc_q[RW-1:N+1];
  assign zero_div  = zero_q;

  // R5: a restored partial remainder always stays below the divisor
  a_r5_partial_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (step && dv_q != '0) |-> (trial.kept < {1'b0, dv_q}));
  // R5: the corrected remainder is below the divisor at completion
  a_r5_final_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !zero_q) |-> (remainder < dv_q));
  // R7: results do not move unless a new operation is loaded or running
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(acc_q));
endmodule

// File: rtl/shreg_divider.sv
module shreg_divider #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic         ready,
  output logic         done,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder,
  output logic         div_by_zero
);
  logic load, step, fin, zero_div;

  shreg_div_ctrl #(.N(N)) ctrl_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .step  (step),
    .ready (ready),
    .fin   (fin)
  );

  shreg_div_datapath #(.N(N)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .fin       (fin),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder),
    .zero_div  (zero_div)
  );

  assign done        = fin;
  assign div_by_zero = fin && zero_div;

  // R3: completion is a single-cycle pulse
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: the zero-divisor flag appears only with done
  a_r6_flag_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !div_by_zero);
  // R2: an accepted start leaves the idle state
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready);
  // R8: idle again right after done
  a_r8_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ready);
endmodule

// File: tb/shreg_divider_tb.sv
`timescale 1ns/1ps
module shreg_divider_tb_top;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         ready, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  shreg_divider #(.N(W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .dividend    (dividend),
    .divisor     (divisor),
    .ready       (ready),
    .done        (done),
    .quotient    (quotient),
    .remainder   (remainder),
    .div_by_zero (div_by_zero)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // issue one division and wait for done, counting sampled negedges
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, output int lat);
    @(negedge clk);
    check(ready, "R8 ready before start", ready, 1);
    dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!ready, "R8 busy after accept", ready, 0);
    lat = 1;
    while (!done && lat < 4 * W + 10) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b);
    int lat;
    issue(a, b, lat);
    check(lat == W + 1, "R3 latency", lat, W + 1);
    if (b != 0) begin
      check(quotient == a / b, "R4 quotient", quotient, a / b);
      check(remainder == a % b, "R5 remainder", remainder, a % b);
      check(remainder < b, "R5 remainder below divisor", remainder, b);
      check(!div_by_zero, "R6 flag low", div_by_zero, 0);
    end else begin
      check(div_by_zero, "R6 flag high on zero divisor", div_by_zero, 1);
    end
    @(negedge clk);
    check(!done, "R3 single-cycle done", done, 0);
    check(ready, "R8 ready after done", ready, 1);
    check(!div_by_zero, "R6 flag low after done", div_by_zero, 0);
  endtask

  task automatic test_reset();
    check(ready == 1'b1, "R1 ready after reset", ready, 1);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(div_by_zero == 1'b0, "R1 flag after reset", div_by_zero, 0);
  endtask

  task automatic test_edges();
    run_div(8'd255, 8'd1);
    run_div(8'd255, 8'd255);
    run_div(8'd0, 8'd7);
    run_div(8'd7, 8'd255);
    run_div(8'd128, 8'd3);
    run_div(8'd255, 8'd128);
    run_div(8'd254, 8'd127);
    run_div(8'd255, 8'd129);
    run_div(8'd100, 8'd10);
  endtask

  task automatic test_zero_div();
    run_div(8'd200, 8'd0);
    run_div(8'd0, 8'd0);
    run_div(8'd9, 8'd4);
  endtask

  // R2: start pulses while busy are ignored
  task automatic test_busy_start();
    int lat;
    @(negedge clk);
    dividend = 8'd250; divisor = 8'd7; start = 1'b1;
    @(negedge clk);
    dividend = 8'd3; divisor = 8'd0;
    repeat (3) @(negedge clk);
    start = 1'b0;
    lat = 4;
    while (!done && lat < 4 * W + 10) begin
      @(negedge clk);
      lat++;
    end
    check(lat == W + 1, "R2 latency unchanged by busy start", lat, W + 1);
    check(quotient == 8'd35, "R2 quotient unaffected", quotient, 35);
    check(remainder == 8'd5, "R2 remainder unaffected", remainder, 5);
    check(!div_by_zero, "R2 flag unaffected", div_by_zero, 0);
    @(negedge clk);
  endtask

  // R7: outputs hold while idle and operands change
  task automatic test_hold();
    run_div(8'd77, 8'd6);
    dividend = 8'd1; divisor = 8'd1;
    repeat (5) @(negedge clk);
    check(quotient == 8'd12, "R7 quotient held", quotient, 12);
    check(remainder == 8'd5, "R7 remainder held", remainder, 5);
    check(!done, "R7 no spurious done", done, 0);
  endtask

  task automatic test_random();
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = W'($urandom);
      if (i % 4 == 0) b = {1'b1, b[W-2:0]};
      if (i % 7 == 0) b = b >> 5;
      run_div(a, b);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_edges();
    test_zero_div();
    test_busy_start();
    test_hold();
    test_random();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule